// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps time of day and calendar date as packed BCD bytes and advances them by one second for every cycle on which the one-pulse-per-second input `tick` is high. Seconds carry into minutes, minutes into hours, and hours into weekday and date. The date carries into month, the month into year, and the year into a century flag. Month lengths follow the Gregorian calendar, except that every year divisible by four is treated as a leap year.

The hours byte can run a 24-hour count or a 12-hour count with a PM flag. The byte itself carries the mode flag, so software selects the mode by writing the hours field. A write port loads any single field. A write takes priority over a tick in the same cycle. A write also pulses `subsec_clr` on the next cycle, so that an external sub-second divider can restart its count.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the outputs read seconds 00h, minutes 00h, hours 00h (24-hour midnight), weekday 01h, date 01h, month 01h (century clear), year 00h, and subsec_clr low.
- R2: Seconds hold BCD 00–59 with tens in bits 6:4, units in bits 3:0 and bit 7 at 0. A tick at 59 gives 00 and advances minutes.
- R3: Minutes use the same format and count 00–59. Minutes change only on a tick while seconds read 59, and 59 rolls to 00 with an hours advance.
- R4: With hours bit 6 clear (24-hour mode), bits 5:4 hold the tens and bits 3:0 the units of 00–23. An advance from 23 gives 00 and advances the day.
- R5: With hours bit 6 set (12-hour mode), bit 5 is PM and bits 4:0 hold BCD 1–12. An advance from 11 gives 12 and inverts PM, and an advance from 12 gives 01. Only the 11 PM to 12 AM step advances the day.
- R6: Weekday sits in bits 2:0 and counts 1–7. At each day advance, 7 gives 1 and any other value goes up by one.
- R7: Date counts BCD 01 to the month's last day, then returns to 01 and advances the month. April, June, September and November have 30 days. February has 29 days when the year is divisible by 4 and 28 otherwise. All other months have 31 days.
- R8: Month sits in bits 4:0 as BCD 01–12, and 12 rolls to 01 with a year advance. Year is a full BCD byte 00–99.
- R9: When the year rolls from 99 to 00, month bit 7 (century) inverts. At every other cycle without a write, that bit holds.
- R10: When wr_en is high, wr_data loads the field selected by wr_addr: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year. Bits outside each field's format load as 0. The whole tick in that cycle is dropped. wr_addr 7 changes nothing.
- R11: subsec_clr is high exactly in the cycle after each cycle with wr_en high.
- R12: With neither tick nor wr_en, every field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second advance strobe, one cycle wide |
| wr_en | input | 1 | Field write enable |
| wr_addr | input | 3 | Field select for the write |
| wr_data | input | 8 | Packed BCD byte to load |
| seconds | output | 8 | Seconds byte |
| minutes | output | 8 | Minutes byte |
| hours | output | 8 | Hours byte with mode and PM flags |
| weekday | output | 8 | Weekday byte |
| date | output | 8 | Date byte |
| month | output | 8 | Month byte with century flag |
| year | output | 8 | Year byte |
| subsec_clr | output | 1 | Restart pulse for the sub-second divider |

## Verification
Every field is a register that drives a port directly, so a wrong next-state value appears at the port one cycle after the tick that caused it. A carry taken at the wrong moment stays wrong from then on, because each field builds on its own previous value. A bad month length or a missed leap year shows at the port only at the end of that month. For this reason the bench places the counter just before each such boundary, in both hour modes and across the century rollover. It also compares all seven bytes on every cycle of long free runs.

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] seconds,
  output logic [7:0] minutes,
  output logic [7:0] hours,
  output logic [7:0] weekday,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic       subsec_clr
);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic       sec_top, min_top, mode12, day_end, leap;
  logic       date_end, mon_end, yr_end;
  logic       roll_min, roll_hr, roll_day, roll_mon, roll_yr;
  logic [4:0] hr12_u, mon_u, lp_sum;
  logic [5:0] hr24_u;
  logic [7:0] hr_next, last_day;

  assign sec_top = seconds >= 8'h59;
  assign min_top = minutes >= 8'h59;
  assign mode12  = hours[6];

  assign hr12_u = (hours[3:0] == 4'd9) ? 5'h10 : {hours[4], hours[3:0] + 4'd1};
  assign hr24_u = (hours[3:0] == 4'd9) ? {hours[5:4] + 2'd1, 4'd0}
                                       : {hours[5:4], hours[3:0] + 4'd1};
  assign day_end = mode12 ? (hours[5] && hours[4:0] == 5'h11) : (hours[5:0] >= 6'h23);

  always_comb begin
    if (mode12) begin
      if (hours[4:0] == 5'h12)      hr_next = {hours[7], 1'b1, hours[5], 5'h01};
      else if (hours[4:0] == 5'h11) hr_next = {hours[7], 1'b1, ~hours[5], 5'h12};
      else                          hr_next = {hours[7], 1'b1, hours[5], hr12_u};
    end else begin
      hr_next = day_end ? 8'h00 : {2'b00, hr24_u};
    end
  end

  assign lp_sum = {year[7:4], 1'b0} + {1'b0, year[3:0]};
  assign leap   = lp_sum[1:0] == 2'd0;

  always_comb begin
    case (month[4:0])
      5'h02:                      last_day = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign mon_u    = (month[3:0] == 4'd9) ? 5'h10 : {month[4], month[3:0] + 4'd1};
  assign date_end = date >= last_day;
  assign mon_end  = month[4:0] >= 5'h12;
  assign yr_end   = year >= 8'h99;

  assign roll_min = tick & sec_top;
  assign roll_hr  = roll_min & min_top;
  assign roll_day = roll_hr & day_end;
  assign roll_mon = roll_day & date_end;
  assign roll_yr  = roll_mon & mon_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seconds    <= 8'h00;
      minutes    <= 8'h00;
      hours      <= 8'h00;
      weekday    <= 8'h01;
      date       <= 8'h01;
      month      <= 8'h01;
      year       <= 8'h00;
      subsec_clr <= 1'b0;
    end else begin
      subsec_clr <= wr_en;
      if (wr_en) begin
        case (wr_addr)
          3'd0: seconds <= {1'b0, wr_data[6:0]};
          3'd1: minutes <= {1'b0, wr_data[6:0]};
          3'd2: hours   <= {1'b0, wr_data[6:0]};
          3'd3: weekday <= {5'b0, wr_data[2:0]};
          3'd4: date    <= {2'b0, wr_data[5:0]};
          3'd5: month   <= {wr_data[7], 2'b0, wr_data[4:0]};
          3'd6: year    <= wr_data;
          default: ;
        endcase
      end else if (tick) begin
        seconds <= sec_top ? 8'h00 : bcd_inc(seconds);
        if (roll_min) minutes <= min_top ? 8'h00 : bcd_inc(minutes);
        if (roll_hr)  hours   <= hr_next;
        if (roll_day) begin
          weekday <= (weekday >= 8'd7) ? 8'd1 : weekday + 8'd1;
          date    <= date_end ? 8'h01 : bcd_inc(date);
        end
        if (roll_mon)
          month <= {month[7] ^ (mon_end & yr_end), month[6:5], mon_end ? 5'h01 : mon_u};
        if (roll_yr)  year <= yr_end ? 8'h00 : bcd_inc(year);
      end
    end
  end

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] seconds,
  input logic [7:0] minutes,
  input logic [7:0] hours,
  input logic [7:0] weekday,
  input logic [7:0] date,
  input logic [7:0] month,
  input logic [7:0] year,
  input logic       subsec_clr
);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> ($stable(seconds) && $stable(minutes) && $stable(hours) &&
                           $stable(weekday) && $stable(date) && $stable(month) && $stable(year)));

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && seconds == 8'h59) |=> seconds == 8'h00);

  assert_min_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && seconds != 8'h59) |=> $stable(minutes));

  assert_century_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && year != 8'h99) |=> month[7] == $past(month[7]));

  assert_wr_sec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> seconds == ($past(wr_data) & 8'h7F));

  assert_wr_month_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd5) |=> month == ($past(wr_data) & 8'h9F));

  assert_clr_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> subsec_clr);

  assert_clr_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !subsec_clr);

endmodule

bind bcd_calendar bcd_calendar_chk u_chk (.*);

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] seconds, minutes, hours, weekday, date, month, year;
  logic subsec_clr;

  int checks = 0, fails = 0;
  int s, m, h, wd, dt, mo, y;
  bit mode12, cent, exp_clr;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar u0 (.clk, .rst_n, .tick, .wr_en, .wr_addr, .wr_data,
                   .seconds, .minutes, .hours, .weekday, .date, .month, .year, .subsec_clr);

  function automatic logic [7:0] tobcd(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction
  function automatic int frombcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int mdays(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] exp_hours();
    int h12;
    if (!mode12) return tobcd(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return 8'h40 | ((h >= 12) ? 8'h20 : 8'h00) | tobcd(h12);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(bit t, bit we, logic [2:0] a, logic [7:0] d);
    exp_clr = we;
    if (we) begin
      case (a)
        3'd0: s = frombcd(d & 8'h7F);
        3'd1: m = frombcd(d & 8'h7F);
        3'd2: begin
          mode12 = d[6];
          if (mode12) h = (frombcd(d & 8'h1F) % 12) + (d[5] ? 12 : 0);
          else h = frombcd(d & 8'h3F);
        end
        3'd3: wd = int'(d[2:0]);
        3'd4: dt = frombcd(d & 8'h3F);
        3'd5: begin mo = frombcd(d & 8'h1F); cent = d[7]; end
        3'd6: y = frombcd(d);
        default: ;
      endcase
    end else if (t) begin
      s++;
      if (s == 60) begin
        s = 0; m++;
        if (m == 60) begin
          m = 0; h++;
          if (h == 24) begin
            h = 0;
            wd = (wd == 7) ? 1 : wd + 1;
            dt++;
            if (dt > mdays(mo, y)) begin
              dt = 1; mo++;
              if (mo == 13) begin
                mo = 1; y++;
                if (y == 100) begin y = 0; cent = ~cent; end
              end
            end
          end
        end
      end
    end
  endtask

  task automatic compare_all();
    chk("R2", seconds, tobcd(s));
    chk("R3", minutes, tobcd(m));
    chk(mode12 ? "R5" : "R4", hours, exp_hours());
    chk("R6", weekday, 8'(wd));
    chk("R7", date, tobcd(dt));
    chk("R8 R9", month, {cent, 2'b00, tobcd(mo)[4:0]});
    chk("R8", year, tobcd(y));
    chk("R11", {7'd0, subsec_clr}, {7'd0, exp_clr});
  endtask

  task automatic cyc(bit t, bit we, logic [2:0] a, logic [7:0] d);
    tick = t; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    model(t, we, a, d);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    compare_all();
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic set_all(logic [7:0] hh, logic [7:0] mm, logic [7:0] ss, logic [7:0] w,
                         logic [7:0] d, logic [7:0] mon, logic [7:0] yy);
    wr(3'd6, yy); wr(3'd5, mon); wr(3'd4, d); wr(3'd3, w);
    wr(3'd2, hh); wr(3'd1, mm); wr(3'd0, ss);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    s = 0; m = 0; h = 0; wd = 1; dt = 1; mo = 1; y = 0; mode12 = 0; cent = 0; exp_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", seconds, 8'h00); chk("R1", minutes, 8'h00); chk("R1", hours, 8'h00);
    chk("R1", weekday, 8'h01); chk("R1", date, 8'h01); chk("R1", month, 8'h01);
    chk("R1", year, 8'h00); chk("R1", {7'd0, subsec_clr}, 8'h00);

    // R12 idle holds
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 3'd0, 8'h00);
    chk("R12", seconds, 8'h00);

    // R7 non-leap February end, R6 weekday 7 -> 1
    set_all(8'h23, 8'h59, 8'h55, 8'h07, 8'h28, 8'h02, 8'h23);
    tk(8);
    chk("R7", date, 8'h01); chk("R7", month, 8'h03); chk("R6", weekday, 8'h01);

    // R7 leap February
    set_all(8'h23, 8'h59, 8'h58, 8'h03, 8'h28, 8'h02, 8'h24);
    tk(3);
    chk("R7", date, 8'h29);
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tk(1);
    chk("R7", date, 8'h01); chk("R7", month, 8'h03);

    // R7 30-day month
    set_all(8'h23, 8'h59, 8'h59, 8'h02, 8'h30, 8'h04, 8'h10);
    tk(1);
    chk("R7", month, 8'h05);

    // R9 century rollover
    set_all(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
    tk(2);
    chk("R9", month, 8'h81); chk("R8", year, 8'h00);

    // R5 12-hour transitions
    set_all(8'h51, 8'h59, 8'h59, 8'h01, 8'h15, 8'h06, 8'h40);
    tk(1);
    chk("R5", hours, 8'h72);
    wr(3'd2, 8'h71); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tk(1);
    chk("R5", hours, 8'h52); chk("R5", date, 8'h16);
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tk(1);
    chk("R5", hours, 8'h41);

    // R10 write beats tick, R11 pulse
    cyc(1'b1, 1'b1, 3'd0, 8'h30);
    chk("R10", seconds, 8'h30); chk("R11", {7'd0, subsec_clr}, 8'h01);
    cyc(1'b0, 1'b0, 3'd0, 8'h00);
    chk("R11", {7'd0, subsec_clr}, 8'h00);
    // R10 address 7 ignored, masking
    cyc(1'b0, 1'b1, 3'd7, 8'hFF);
    chk("R10", seconds, 8'h30); chk("R10", hours, 8'h41);
    wr(3'd0, 8'hA5);
    chk("R10", seconds, 8'h25);
    wr(3'd3, 8'hFE);
    chk("R10", weekday, 8'h06);

    // Long runs, both hour modes
    set_all(8'h22, 8'h00, 8'h00, 8'h04, 8'h27, 8'h02, 8'h99);
    tk(40000);
    set_all(8'h51, 8'h00, 8'h00, 8'h07, 8'h30, 8'h11, 8'h03);
    tk(40000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule